// File: doc/BRIEF.md
# Wireless MAC Key Table

This block holds the per-station cipher keys of a wireless MAC. Software loads each table entry through a 32-bit register port. Every entry is eight words: five key words, one cipher-type word and two words that hold the peer station address. The table stores its words as 64-bit pairs. A write to an even word is parked in a single staging register. The pair is written to the table only when the odd word of the pair arrives, so a half-written pair never changes a live entry.

The receive path presents a 48-bit transmitter address on the lookup port. All entries are compared in parallel. The block returns the lowest-index valid entry whose stored address matches, together with its cipher code and its 128 bits of key material. When the matched entry is a TKIP entry, the block also gives the index of the companion slot that holds its Michael keys. That slot lies a fixed distance above the entry.

Top module: `keytab_cache`

## Requirements
- R1: Byte address `BASE_ADDR + index*32 + word*4` selects a word: words 0 to 4 are key words, word 5 the cipher word, word 6 the low address word and word 7 the high address word. Addresses below the base, at or past the table end, or not 4-byte aligned are ignored by writes and read as zero. Read data appears on `reg_rdata` with `reg_rvalid` one cycle after `reg_rd`.
- R2: A write to an even word changes no stored word. A read of that even word still returns the previously committed value.
- R3: A write to an odd word commits the pair `{odd data, staged even data}` when the staging register holds an even write to the same entry and pair. The commit empties the staging register.
- R4: An odd write with no matching staged even word commits `{odd data, current committed even word}`. It leaves the even word unchanged and also empties the staging register.
- R5: A synchronous reset sets every stored word to zero, so reads return zero and no lookup hits.
- R6: An entry matches when bit 15 of word 7 is set and `{word7[14:0], word6}` equals transmitter address bits 47:1. Address bit 0 is ignored. `lk_done` pulses one cycle after `lk_req`, with the result.
- R7: An entry whose bit 15 of word 7 is clear never matches, whatever its address.
- R8: When several entries match, `lk_index` is the lowest matching index.
- R9: On a hit, `lk_cipher` is bits 2:0 of word 5. `lk_key` is `{word4, word3[15:0], word2, word1[15:0], word0}`. On a miss, `lk_hit`, `lk_index`, `lk_cipher` and `lk_key` are zero.
- R10: The cipher codes are clear 0, WEP-40 1, WEP-104 2, WEP-128 3, TKIP 4, AES-OCB 5 and AES-CCM 6. `lk_mic_ok` is 1 exactly when the hit entry has code 4 and `index + MIC_OFFSET < N_ENTRIES`. Then `lk_mic_index = index + MIC_OFFSET`; otherwise both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| reg_rvalid | output | 1 | Read data valid |
| lk_req | input | 1 | Lookup request |
| lk_ta | input | 48 | Transmitter address to look up |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | A valid entry matched |
| lk_index | output | IDX_W | Index of matching entry |
| lk_cipher | output | 3 | Cipher code of matching entry |
| lk_key | output | 128 | Key material of matching entry |
| lk_mic_ok | output | 1 | Companion Michael slot is usable |
| lk_mic_index | output | IDX_W | Index of the companion Michael slot |

## Verification
The bench first stages an even word and reads it back before the pair is completed. A design that commits on the even write returns the new value there instead of the old one. Next it sends an odd write to a different pair while another even word is still staged. A design that ignores the staged pair's identity writes the wrong even word, and one that keeps the staging register after a commit later corrupts the first pair. The lookups cover several more cases:
- a transmitter address differing only in bit 0;
- an entry with a matching address but the flag clear;
- two valid entries with the same address;
- TKIP entries whose companion slot falls inside the table and past its end.

Each case exposes a design that compares the wrong bits, ignores the flag, picks the highest index or computes the companion slot without bounds.

// File: rtl/keytab_pkg.sv
package keytab_pkg;

    typedef enum logic [2:0] {
        CIPH_CLEAR   = 3'd0,
        CIPH_WEP40   = 3'd1,
        CIPH_WEP104  = 3'd2,
        CIPH_WEP128  = 3'd3,
        CIPH_TKIP    = 3'd4,
        CIPH_AES_OCB = 3'd5,
        CIPH_AES_CCM = 3'd6
    } cipher_e;

    localparam int PAIRS_PER_ENTRY = 4;
    localparam int PAIR_ADDR       = 3;   // pair holding the two address words
    localparam int PAIR_TYPE       = 2;   // pair holding key word 4 and the cipher word
    localparam int FLAG_BIT        = 47;  // bit 15 of word 7 inside pair 3

    typedef logic [PAIRS_PER_ENTRY-1:0][63:0] entry_t;

    // Gather the meaningful key bits of an entry into one vector.
    function automatic logic [127:0] gather_key(entry_t e);
        return {e[2][31:0], e[1][47:32], e[1][31:0], e[0][47:32], e[0][31:0]};
    endfunction

endpackage

// File: rtl/keytab_decode.sv
module keytab_decode #(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h1000,
    parameter int              N_ENTRIES = 128,
    parameter int              IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range,
    output logic [IDX_W-1:0]  entry,
    output logic [2:0]        word
);
    localparam int TABLE_BYTES = N_ENTRIES * 32;

    logic [ADDR_W-1:0] off;

    always_comb begin
        off      = addr - BASE_ADDR;
        in_range = (addr >= BASE_ADDR)
                && ({{(32-ADDR_W){1'b0}}, off} < 32'(TABLE_BYTES))
                && (off[1:0] == 2'b00);
        entry    = off[IDX_W+4:5];
        word     = off[4:2];
    end

endmodule

// File: rtl/keytab_match.sv
module keytab_match #(
    parameter int N_ENTRIES = 128,
    parameter int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_ENTRIES-1:0][47:0] tags,   // {flag, stored address bits 47:1}
    input  logic [46:0]                ta_hi,
    output logic                       hit,
    output logic [IDX_W-1:0]           idx
);
    logic [N_ENTRIES-1:0] hv;

    for (genvar gi = 0; gi < N_ENTRIES; gi++) begin : g_cmp
        assign hv[gi] = tags[gi][47] && (tags[gi][46:0] == ta_hi);
    end

    always_comb begin
        hit = |hv;
        idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (hv[i]) idx = IDX_W'(i);
        end
    end

    // Chosen entry carries the flag (R7)
    p_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
        hit |-> tags[idx][47]);
    // Chosen entry's address equals the looked-up address (R6)
    p_addr_eq_r6: assert property (@(posedge clk) disable iff (rst)
        hit |-> (tags[idx][46:0] == ta_hi));
    // No lower index matched (R8)
    p_lowest_r8: assert property (@(posedge clk) disable iff (rst)
        hit |-> ((hv & ((N_ENTRIES'(1) << idx) - N_ENTRIES'(1))) == '0));

endmodule

// File: rtl/keytab_cache.sv
module keytab_cache
    import keytab_pkg::*;
#(
    parameter int                N_ENTRIES  = 128,
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 16'h1000,
    parameter int                MIC_OFFSET = 64,
    localparam int               IDX_W      = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_rvalid,
    input  logic              lk_req,
    input  logic [47:0]       lk_ta,
    output logic              lk_done,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_index,
    output logic [2:0]        lk_cipher,
    output logic [127:0]      lk_key,
    output logic              lk_mic_ok,
    output logic [IDX_W-1:0]  lk_mic_index
);
    typedef struct packed {
        logic             stg_v;
        logic [IDX_W-1:0] stg_e;
        logic [1:0]       stg_p;
        logic [31:0]      stg_w;
        logic             rvalid;
        logic [31:0]      rdata;
        logic             done;
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic [2:0]       ciph;
        logic [127:0]     key;
        logic             mic_ok;
        logic [IDX_W-1:0] mic_idx;
    } ctl_t;

    ctl_t                    c_d, c_q;
    entry_t [N_ENTRIES-1:0]  mem_d, mem_q;

    logic                       dec_in;
    logic [IDX_W-1:0]           dec_ent;
    logic [2:0]                 dec_word;
    logic [N_ENTRIES-1:0][47:0] tags;
    logic                       m_hit;
    logic [IDX_W-1:0]           m_idx;

    keytab_decode #(
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
        .N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)
    ) u_dec (
        .addr(reg_addr), .in_range(dec_in), .entry(dec_ent), .word(dec_word)
    );

    for (genvar gi = 0; gi < N_ENTRIES; gi++) begin : g_tag
        assign tags[gi] = mem_q[gi][PAIR_ADDR][FLAG_BIT:0];
    end

    keytab_match #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_match (
        .clk(clk), .rst(rst), .tags(tags), .ta_hi(lk_ta[47:1]),
        .hit(m_hit), .idx(m_idx)
    );

    always_comb begin
        logic [31:0] even_w;
        logic [2:0]  ciph;
        logic        mic;
        c_d       = c_q;
        mem_d     = mem_q;
        even_w    = '0;
        ciph      = '0;
        mic       = 1'b0;
        c_d.rvalid = reg_rd;
        c_d.rdata  = '0;
        c_d.done   = lk_req;

        if (reg_rd && dec_in) begin
            c_d.rdata = dec_word[0] ? mem_q[dec_ent][dec_word[2:1]][63:32]
                                    : mem_q[dec_ent][dec_word[2:1]][31:0];
        end

        if (reg_wr && dec_in) begin
            if (!dec_word[0]) begin
                c_d.stg_v = 1'b1;
                c_d.stg_e = dec_ent;
                c_d.stg_p = dec_word[2:1];
                c_d.stg_w = reg_wdata;
            end else begin
                if (c_q.stg_v && c_q.stg_e == dec_ent && c_q.stg_p == dec_word[2:1])
                    even_w = c_q.stg_w;
                else
                    even_w = mem_q[dec_ent][dec_word[2:1]][31:0];
                mem_d[dec_ent][dec_word[2:1]] = {reg_wdata, even_w};
                c_d.stg_v = 1'b0;
            end
        end

        if (lk_req) begin
            c_d.hit     = m_hit;
            c_d.idx     = '0;
            c_d.ciph    = '0;
            c_d.key     = '0;
            c_d.mic_ok  = 1'b0;
            c_d.mic_idx = '0;
            if (m_hit) begin
                ciph        = mem_q[m_idx][PAIR_TYPE][34:32];
                mic         = (ciph == CIPH_TKIP)
                           && (int'(m_idx) + MIC_OFFSET < N_ENTRIES);
                c_d.idx     = m_idx;
                c_d.ciph    = ciph;
                c_d.key     = gather_key(mem_q[m_idx]);
                c_d.mic_ok  = mic;
                c_d.mic_idx = mic ? IDX_W'(int'(m_idx) + MIC_OFFSET) : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q   <= '0;
            mem_q <= '0;
        end else begin
            c_q   <= c_d;
            mem_q <= mem_d;
        end
    end

    assign reg_rdata    = c_q.rdata;
    assign reg_rvalid   = c_q.rvalid;
    assign lk_done      = c_q.done;
    assign lk_hit       = c_q.hit;
    assign lk_index     = c_q.idx;
    assign lk_cipher    = c_q.ciph;
    assign lk_key       = c_q.key;
    assign lk_mic_ok    = c_q.mic_ok;
    assign lk_mic_index = c_q.mic_idx;

    // Read data follows the strobe by one cycle (R1)
    p_rd_latency_r1: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> reg_rvalid);
    // Unmapped reads return zero (R1)
    p_oob_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !dec_in) |=> (reg_rdata == '0));
    // Even-word writes leave the table untouched (R2)
    p_even_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && dec_in && !dec_word[0]) |=> $stable(mem_q));
    // Every odd-word commit empties staging (R3)
    p_commit_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && dec_in && dec_word[0]) |=> !c_q.stg_v);
    // Lookup answers one cycle later (R6)
    p_lk_latency_r6: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> lk_done);
    // Companion slot only for in-range TKIP hits (R10)
    p_mic_legal_r10: assert property (@(posedge clk) disable iff (rst)
        lk_mic_ok |-> (lk_hit && lk_cipher == CIPH_TKIP
                       && int'(lk_index) + MIC_OFFSET < N_ENTRIES));

endmodule

// File: tb/sim_keytab_cache.sv
`timescale 1ns/1ps
module sim_keytab_cache;
    localparam int          N    = 128;
    localparam logic [15:0] BASE = 16'h1000;

    typedef struct packed {
        logic         kind;     // 0 read, 1 lookup
        logic [31:0]  rdata;
        logic         hit;
        logic [6:0]   idx;
        logic [2:0]   ciph;
        logic [127:0] key;
        logic         mic_ok;
        logic [6:0]   mic_idx;
    } exp_t;

    logic         clk = 0, rst = 1;
    logic         reg_wr = 0, reg_rd = 0, lk_req = 0;
    logic [15:0]  reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [47:0]  lk_ta = '0;
    logic [31:0]  reg_rdata;
    logic         reg_rvalid, lk_done, lk_hit, lk_mic_ok;
    logic [6:0]   lk_index, lk_mic_index;
    logic [2:0]   lk_cipher;
    logic [127:0] lk_key;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    exp_t  exp_q[$];
    string tag_q[$];

    logic [31:0] mdl [N][8];
    bit          s_v;
    int          s_e, s_p;
    logic [31:0] s_w;

    always #4 clk = ~clk;

    keytab_cache u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .lk_req(lk_req), .lk_ta(lk_ta),
        .lk_done(lk_done), .lk_hit(lk_hit), .lk_index(lk_index),
        .lk_cipher(lk_cipher), .lk_key(lk_key), .lk_mic_ok(lk_mic_ok),
        .lk_mic_index(lk_mic_index)
    );

    task automatic model_clear();
        for (int e = 0; e < N; e++)
            for (int w = 0; w < 8; w++) mdl[e][w] = '0;
        s_v = 0;
    endtask

    task automatic wr(int e, int w, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = BASE + 16'(e*32 + w*4); reg_wdata = d;
        if (w % 2 == 0) begin
            s_v = 1; s_e = e; s_p = w / 2; s_w = d;
        end else begin
            if (!(s_v && s_e == e && s_p == w / 2)) s_w = mdl[e][w-1];
            mdl[e][w-1] = s_w; mdl[e][w] = d; s_v = 0;
        end
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic wr_raw(logic [15:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_raw(logic [15:0] a, logic [31:0] expv, string tag);
        exp_t x;
        @(negedge clk);
        x = '0; x.kind = 0; x.rdata = expv;
        exp_q.push_back(x); tag_q.push_back(tag);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic rd(int e, int w, string tag);
        rd_raw(BASE + 16'(e*32 + w*4), mdl[e][w], tag);
    endtask

    task automatic look(logic [47:0] ta, string tag);
        exp_t x;
        x = '0; x.kind = 1;
        for (int i = 0; i < N; i++) begin
            if (!x.hit && mdl[i][7][15] && {mdl[i][7][14:0], mdl[i][6]} == ta[47:1]) begin
                x.hit  = 1; x.idx = 7'(i); x.ciph = mdl[i][5][2:0];
                x.key  = {mdl[i][4], mdl[i][3][15:0], mdl[i][2], mdl[i][1][15:0], mdl[i][0]};
                x.mic_ok  = (x.ciph == 3'd4) && (i + 64 < N);
                x.mic_idx = x.mic_ok ? 7'(i + 64) : 7'd0;
            end
        end
        @(negedge clk);
        exp_q.push_back(x); tag_q.push_back(tag);
        lk_req = 1; lk_ta = ta;
        @(negedge clk);
        lk_req = 0;
    endtask

    task automatic put_entry(int e, logic [2:0] ciph, logic [47:0] mac, bit flag);
        wr(e, 0, 32'hC000_0000 + 32'(e));
        wr(e, 1, 32'h0000_5A00 + 32'(e));
        wr(e, 2, 32'h1234_0000 + 32'(e));
        wr(e, 3, 32'h0000_7700 + 32'(e));
        wr(e, 4, 32'h9900_0000 + 32'(e));
        wr(e, 5, {29'd0, ciph});
        wr(e, 6, mac[32:1]);
        wr(e, 7, {16'd0, flag, mac[47:33]});
    endtask

    always @(negedge clk) begin
        if (!rst && (reg_rvalid || lk_done)) begin
            exp_t x; string t;
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected output: rvalid %0b done %0b, expected none", reg_rvalid, lk_done);
            end else begin
                x = exp_q.pop_front(); t = tag_q.pop_front();
                if (x.kind == 0) begin
                    if (!reg_rvalid || reg_rdata !== x.rdata) begin
                        n_fail++;
                        $display("FAIL %s read: actual %h (valid %0b) expected %h", t, reg_rdata, reg_rvalid, x.rdata);
                    end
                end else if (!lk_done || lk_hit !== x.hit || lk_index !== x.idx
                             || lk_cipher !== x.ciph || lk_key !== x.key
                             || lk_mic_ok !== x.mic_ok || lk_mic_index !== x.mic_idx) begin
                    n_fail++;
                    $display("FAIL %s lookup: actual hit %0b idx %0d ciph %0d mic %0b/%0d key %h expected hit %0b idx %0d ciph %0d mic %0b/%0d key %h",
                             t, lk_hit, lk_index, lk_cipher, lk_mic_ok, lk_mic_index, lk_key,
                             x.hit, x.idx, x.ciph, x.mic_ok, x.mic_idx, x.key);
                end
            end
        end
    end

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    localparam logic [47:0] MAC_A = 48'h0012_3456_789A;
    localparam logic [47:0] MAC_B = 48'h00AB_CDEF_0102;
    localparam logic [47:0] MAC_C = 48'h0ACE_1357_9BDF;
    localparam logic [47:0] MAC_D = 48'h0F0E_0D0C_0B0A;

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R5: outputs idle after reset
        n_chk++;
        if (reg_rvalid !== 1'b0 || lk_done !== 1'b0) begin
            n_fail++;
            $display("FAIL R5 idle: actual rvalid %0b done %0b expected 0 0", reg_rvalid, lk_done);
        end
        rd(0, 7, "R5");
        look(48'h0, "R5");

        // R1 / R3 / R9: full entry load, read back, lookup
        put_entry(3, 3'd2, MAC_A, 1);
        for (int w = 0; w < 8; w++) rd(3, w, "R1");
        look(MAC_A, "R9");
        look(MAC_A ^ 48'h1, "R6");
        look(MAC_B, "R6");

        // R2 then R3
        wr(3, 0, 32'hDEAD_BEEF);
        rd(3, 0, "R2");
        wr(3, 1, 32'h0000_4321);
        rd(3, 0, "R3");
        rd(3, 1, "R3");

        // R4: odd write to a different pair while another pair is staged
        wr(3, 2, 32'h5555_AAAA);
        wr(5, 1, 32'h0000_0BEE);
        rd(5, 0, "R4");
        rd(5, 1, "R4");
        wr(3, 3, 32'h0000_0C0C);
        rd(3, 2, "R4");
        rd(3, 3, "R4");

        // R7: flag clear never matches
        put_entry(10, 3'd1, MAC_B, 0);
        look(MAC_B, "R7");

        // R8 and R10: duplicates, lowest index, companion slot
        put_entry(20, 3'd6, MAC_C, 1);
        put_entry(7, 3'd4, MAC_C, 1);
        look(MAC_C, "R8");
        put_entry(70, 3'd4, MAC_D, 1);
        look(MAC_D, "R10");

        // R1: unmapped, misaligned addresses
        wr_raw(BASE + 16'd4096 + 16'd4, 32'hFFFF_FFFF);
        wr_raw(BASE - 16'd4, 32'hFFFF_FFFF);
        wr_raw(BASE + 16'd2, 32'h1111_1111);
        wr_raw(BASE + 16'd7, 32'h2222_2222);
        rd(0, 0, "R1");
        rd(0, 1, "R1");
        rd_raw(BASE + 16'd4096, 32'h0, "R1");
        rd_raw(BASE - 16'd4, 32'h0, "R1");
        rd_raw(BASE + 16'd6 * 16'd32 + 16'd1, 32'h0, "R1");

        // R5: reset wipes loaded entries
        @(negedge clk); rst = 1;
        @(negedge clk); @(negedge clk); rst = 0;
        model_clear();
        look(MAC_A, "R5");
        rd(3, 7, "R5");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL pending: actual %0d outputs missing expected 0", exp_q.size());
        end
        finish_up();
    end
endmodule